// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block is the exception-control slice of a 32-bit core. Each cycle it looks at the instruction presented for completion, together with the fault flags raised by the fetch, decode, execute and memory stages, six hardware interrupt lines and a non-maskable interrupt input. When a request wins arbitration it records the return address, a cause code and, for address faults, the offending virtual address. It then switches the core to kernel mode and tells the fetch unit to restart at the single kernel vector.

The block also executes the return-from-exception instruction. It restarts fetch at the saved return address and drops the core back to user mode. It finds address faults itself: misaligned fetch or data accesses, and user-mode references to the upper (kernel) half of the address space. It decodes the system-call, breakpoint and exception-return encodings from the instruction word. A small control register holds the mode bit and the per-line interrupt enables. Kernel code can write this register through a simple write strobe.

Top module: `trap_unit`

## Requirements
- R1: Whenever an exception is taken in a cycle, the next cycle shows `redirect_valid`=1, `redirect_pc`=0x80000180 and `kernel_mode`=1.
- R2: The saved return address (`epc_out`) is the presented PC for address errors, bus errors and reserved instructions, and also for NMI and hardware interrupts (the presented instruction has not run). It is the presented PC + 4 for syscall, breakpoint, overflow, trap and floating-point faults.
- R3: The cause codes are: hardware interrupt and NMI 0, load or fetch address error 4, store address error 5, fetch bus error 6, data bus error 7, syscall 8, breakpoint 9, reserved instruction 10, overflow 12, trap 13, floating-point 15.
- R4: `badvaddr_out` is written only by an address error: the fetch PC for a fetch fault, `mem_vaddr` for a data fault. Any other cause leaves it unchanged.
- R5: A fetch address error is `ex_pc[1:0]`≠0, or user mode with `ex_pc[31]`=1. A data address error needs `mem_ld` or `mem_st`. It is a misalignment under `mem_size` (0 byte, 1 halfword needing bit 0 clear, 2 or 3 word needing bits 1:0 clear), or user mode with `mem_vaddr[31]`=1.
- R6: Opcode bits [31:26]=0 with function bits [5:0]=0x0C is a syscall, and function 0x0D is a breakpoint. The word 0x42000018 is exception return. In user mode that word is a reserved instruction.
- R7: A hardware interrupt is taken only when `ex_valid`=1, the core is in user mode, and some line is high with its enable bit set.
- R8: NMI becomes pending on a 0→1 change of `nmi_in` seen by the clock. It is taken on the next cycle with `ex_valid`=1, in either mode. A level held high through reset is not an edge.
- R9: When requests coincide, the order is NMI, fetch address error, fetch bus error, reserved instruction, syscall, breakpoint, overflow, trap, floating-point, data address error, data bus error, hardware interrupt, exception return.
- R10: Exception return in kernel mode gives, next cycle, `redirect_valid`=1 with `redirect_pc` equal to the saved return address and `kernel_mode`=0. The return address, cause and bad address are unchanged.
- R11: After reset the core is in kernel mode, all interrupt enables are 0, the saved registers are 0 and `redirect_valid` is 0.
- R12: `csr_we` loads `csr_wdata[0]` into the mode bit and `csr_wdata[6:1]` into the interrupt enables. This happens only in kernel mode and only when no exception or return is taken that cycle; otherwise the write is ignored.
- R13: The return address, cause and bad address registers change only in a cycle in which an exception is taken. `redirect_valid` is 0 after cycles with no exception and no return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ex_valid | input | 1 | An instruction is presented for completion |
| ex_pc | input | 32 | Address of the presented instruction |
| ex_instr | input | 32 | Presented instruction word |
| resv_in | input | 1 | Decoder found an undefined opcode |
| ibus_err | input | 1 | Fetch of the presented instruction hit a bus error |
| ovf_in | input | 1 | Integer overflow |
| trap_in | input | 1 | Trap condition of a trap instruction is true |
| fpe_in | input | 1 | Floating-point unit raised a fault |
| mem_ld | input | 1 | Instruction performs a load |
| mem_st | input | 1 | Instruction performs a store |
| mem_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| mem_vaddr | input | 32 | Data virtual address |
| dbus_err | input | 1 | Data access hit a bus error |
| irq_in | input | 6 | Hardware interrupt lines |
| nmi_in | input | 1 | Non-maskable interrupt input |
| csr_we | input | 1 | Control register write strobe |
| csr_wdata | input | 7 | Bit 0 mode, bits 6:1 interrupt enables |
| redirect_valid | output | 1 | Fetch must restart at `redirect_pc` |
| redirect_pc | output | 32 | Restart address |
| kernel_mode | output | 1 | 1 = kernel, 0 = user |
| irq_mask | output | 6 | Interrupt enable bits |
| epc_out | output | 32 | Saved return address |
| cause_out | output | 5 | Saved cause code |
| badvaddr_out | output | 32 | Saved faulting address |

## Verification
The bench drives instructions that carry several faults at once, such as a syscall with a pending interrupt or a misaligned fetch together with a data fault. A wrong priority chain would record the wrong cause or a return address offset by 4. It holds the NMI input high through reset and checks that no entry follows. A plain level test would enter the handler at once. It tries control-register writes from user mode, which would let user code re-enter kernel mode if honoured. It also tries exception return from user mode, which must become a reserved-instruction fault and not a redirect to the saved address. Load and store address errors at every size check that the right cause is chosen and that the bad-address register is left alone for every other cause.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam int XLEN = 32;

    typedef enum logic [4:0] {
        EC_INT  = 5'd0,
        EC_ADEL = 5'd4,
        EC_ADES = 5'd5,
        EC_IBE  = 5'd6,
        EC_DBE  = 5'd7,
        EC_SYS  = 5'd8,
        EC_BP   = 5'd9,
        EC_RI   = 5'd10,
        EC_OV   = 5'd12,
        EC_TR   = 5'd13,
        EC_FPE  = 5'd15
    } exc_code_e;

    // fault flags gathered from the pipeline for the presented instruction
    typedef struct packed {
        logic if_adr;
        logic if_bus;
        logic ri;
        logic sys;
        logic bp;
        logic ov;
        logic tr;
        logic fpe;
        logic d_adr;
        logic d_bus;
        logic d_store;
        logic eret;
    } flt_t;

    // outcome of arbitration
    typedef struct packed {
        logic            take;
        logic            nmi;
        exc_code_e       code;
        logic            epc_next;
        logic            bad_we;
        logic [XLEN-1:0] bad_val;
    } sel_t;

    localparam logic [XLEN-1:0] ERET_WORD = 32'h4200_0018;
    localparam logic [5:0]      FN_SYS    = 6'h0C;
    localparam logic [5:0]      FN_BRK    = 6'h0D;

endpackage

// File: rtl/trap_detect.sv
module trap_detect
    import trap_pkg::*;
(
    input  logic            kmode,
    input  logic            ex_valid,
    input  logic [XLEN-1:0] ex_pc,
    input  logic [XLEN-1:0] ex_instr,
    input  logic            resv_in,
    input  logic            ibus_err,
    input  logic            ovf_in,
    input  logic            trap_in,
    input  logic            fpe_in,
    input  logic            mem_ld,
    input  logic            mem_st,
    input  logic [1:0]      mem_size,
    input  logic [XLEN-1:0] mem_vaddr,
    input  logic            dbus_err,
    output flt_t            flt
);
    logic is_eret;
    logic is_special;
    logic misalign;

    always_comb begin
        flt        = '0;
        is_eret    = (ex_instr == ERET_WORD);
        is_special = (ex_instr[31:26] == 6'd0);
        unique case (mem_size)
            2'd0:    misalign = 1'b0;
            2'd1:    misalign = mem_vaddr[0];
            default: misalign = (mem_vaddr[1:0] != 2'b00);
        endcase
        if (ex_valid) begin
            flt.if_adr = (ex_pc[1:0] != 2'b00) || (!kmode && ex_pc[XLEN-1]);
            flt.if_bus = ibus_err;
            flt.ri     = resv_in || (is_eret && !kmode);
            flt.eret   = is_eret && kmode;
            flt.sys    = is_special && (ex_instr[5:0] == FN_SYS);
            flt.bp     = is_special && (ex_instr[5:0] == FN_BRK);
            flt.ov     = ovf_in;
            flt.tr     = trap_in;
            flt.fpe    = fpe_in;
            if (mem_ld || mem_st) begin
                flt.d_adr   = misalign || (!kmode && mem_vaddr[XLEN-1]);
                flt.d_bus   = dbus_err;
                flt.d_store = mem_st;
            end
        end
    end

endmodule

// File: rtl/trap_irq.sv
module trap_irq #(
    parameter int NIRQ = 6
) (
    input  logic            enable,
    input  logic [NIRQ-1:0] irq_in,
    input  logic [NIRQ-1:0] imask,
    output logic            irq_go
);
    logic [NIRQ-1:0] hit;

    for (genvar i = 0; i < NIRQ; i++) begin : g_line
        assign hit[i] = irq_in[i] & imask[i];
    end

    assign irq_go = enable && (|hit);

endmodule

// File: rtl/trap_prio.sv
module trap_prio
    import trap_pkg::*;
(
    input  logic            nmi_go,
    input  logic            irq_go,
    input  flt_t            flt,
    input  logic [XLEN-1:0] ex_pc,
    input  logic [XLEN-1:0] mem_vaddr,
    output sel_t            sel,
    output logic            eret_go
);
    always_comb begin
        sel      = '0;
        sel.code = EC_INT;
        eret_go  = 1'b0;
        if (nmi_go) begin
            sel.take = 1'b1;
            sel.nmi  = 1'b1;
        end else if (flt.if_adr) begin
            sel.take    = 1'b1;
            sel.code    = EC_ADEL;
            sel.bad_we  = 1'b1;
            sel.bad_val = ex_pc;
        end else if (flt.if_bus) begin
            sel.take = 1'b1;
            sel.code = EC_IBE;
        end else if (flt.ri) begin
            sel.take = 1'b1;
            sel.code = EC_RI;
        end else if (flt.sys) begin
            sel.take     = 1'b1;
            sel.code     = EC_SYS;
            sel.epc_next = 1'b1;
        end else if (flt.bp) begin
            sel.take     = 1'b1;
            sel.code     = EC_BP;
            sel.epc_next = 1'b1;
        end else if (flt.ov) begin
            sel.take     = 1'b1;
            sel.code     = EC_OV;
            sel.epc_next = 1'b1;
        end else if (flt.tr) begin
            sel.take     = 1'b1;
            sel.code     = EC_TR;
            sel.epc_next = 1'b1;
        end else if (flt.fpe) begin
            sel.take     = 1'b1;
            sel.code     = EC_FPE;
            sel.epc_next = 1'b1;
        end else if (flt.d_adr) begin
            sel.take    = 1'b1;
            sel.code    = flt.d_store ? EC_ADES : EC_ADEL;
            sel.bad_we  = 1'b1;
            sel.bad_val = mem_vaddr;
        end else if (flt.d_bus) begin
            sel.take = 1'b1;
            sel.code = EC_DBE;
        end else if (irq_go) begin
            sel.take = 1'b1;
        end else if (flt.eret) begin
            eret_go = 1'b1;
        end
    end

endmodule

// File: rtl/trap_unit.sv
module trap_unit
    import trap_pkg::*;
#(
    parameter int              NIRQ = 6,
    parameter logic [XLEN-1:0] VEC  = 32'h8000_0180
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ex_valid,
    input  logic [XLEN-1:0] ex_pc,
    input  logic [XLEN-1:0] ex_instr,
    input  logic            resv_in,
    input  logic            ibus_err,
    input  logic            ovf_in,
    input  logic            trap_in,
    input  logic            fpe_in,
    input  logic            mem_ld,
    input  logic            mem_st,
    input  logic [1:0]      mem_size,
    input  logic [XLEN-1:0] mem_vaddr,
    input  logic            dbus_err,
    input  logic [NIRQ-1:0] irq_in,
    input  logic            nmi_in,
    input  logic            csr_we,
    input  logic [NIRQ:0]   csr_wdata,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_pc,
    output logic            kernel_mode,
    output logic [NIRQ-1:0] irq_mask,
    output logic [XLEN-1:0] epc_out,
    output logic [4:0]      cause_out,
    output logic [XLEN-1:0] badvaddr_out
);
    localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

    typedef struct packed {
        logic            kmode;
        logic [NIRQ-1:0] imask;
        logic [XLEN-1:0] epc;
        exc_code_e       cause;
        logic [XLEN-1:0] badva;
        logic            nmi_prev;
        logic            nmi_pend;
        logic            rd_valid;
        logic [XLEN-1:0] rd_pc;
    } st_t;

    st_t  q, d;
    flt_t flt;
    sel_t sel;
    logic irq_go;
    logic nmi_go;
    logic eret_go;
    logic take_w;

    trap_detect u_detect (
        .kmode     (q.kmode),
        .ex_valid  (ex_valid),
        .ex_pc     (ex_pc),
        .ex_instr  (ex_instr),
        .resv_in   (resv_in),
        .ibus_err  (ibus_err),
        .ovf_in    (ovf_in),
        .trap_in   (trap_in),
        .fpe_in    (fpe_in),
        .mem_ld    (mem_ld),
        .mem_st    (mem_st),
        .mem_size  (mem_size),
        .mem_vaddr (mem_vaddr),
        .dbus_err  (dbus_err),
        .flt       (flt)
    );

    trap_irq #(.NIRQ(NIRQ)) u_irq (
        .enable (ex_valid && !q.kmode),
        .irq_in (irq_in),
        .imask  (q.imask),
        .irq_go (irq_go)
    );

    assign nmi_go = ex_valid && q.nmi_pend;

    trap_prio u_prio (
        .nmi_go    (nmi_go),
        .irq_go    (irq_go),
        .flt       (flt),
        .ex_pc     (ex_pc),
        .mem_vaddr (mem_vaddr),
        .sel       (sel),
        .eret_go   (eret_go)
    );

    assign take_w = sel.take;

    always_comb begin
        d          = q;
        d.rd_valid = 1'b0;
        d.nmi_prev = nmi_in;
        if (sel.take) begin
            d.kmode    = 1'b1;
            d.epc      = sel.epc_next ? (ex_pc + INSN_BYTES) : ex_pc;
            d.cause    = sel.code;
            d.rd_valid = 1'b1;
            d.rd_pc    = VEC;
            if (sel.bad_we) begin
                d.badva = sel.bad_val;
            end
            if (sel.nmi) begin
                d.nmi_pend = 1'b0;
            end
        end else if (eret_go) begin
            d.kmode    = 1'b0;
            d.rd_valid = 1'b1;
            d.rd_pc    = q.epc;
        end else if (csr_we && q.kmode) begin
            d.kmode = csr_wdata[0];
            d.imask = csr_wdata[NIRQ:1];
        end
        if (nmi_in && !q.nmi_prev) begin
            d.nmi_pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.kmode    <= 1'b1;
            q.nmi_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign redirect_valid = q.rd_valid;
    assign redirect_pc    = q.rd_pc;
    assign kernel_mode    = q.kmode;
    assign irq_mask       = q.imask;
    assign epc_out        = q.epc;
    assign cause_out      = q.cause;
    assign badvaddr_out   = q.badva;

endmodule

// File: rtl/trap_unit_chk.sv
module trap_unit_chk #(
    parameter logic [31:0] VEC = 32'h8000_0180
) (
    input logic        clk,
    input logic        rst_n,
    input logic        take,
    input logic        eret_go,
    input logic        csr_we,
    input logic        redirect_valid,
    input logic [31:0] redirect_pc,
    input logic        kernel_mode,
    input logic [31:0] epc,
    input logic [4:0]  cause,
    input logic [31:0] badva
);
    a_r1_vector_entry: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (redirect_valid && redirect_pc == VEC && kernel_mode));

    a_r10_return_path: assert property (@(posedge clk) disable iff (!rst_n)
        eret_go |=> (redirect_valid && redirect_pc == $past(epc) && !kernel_mode));

    a_r13_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> ($stable(epc) && $stable(cause) && $stable(badva)));

    a_r13_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> $past(take || eret_go));

    a_r9_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({take, eret_go}));

    a_r12_user_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(kernel_mode) |-> $past(eret_go || csr_we));

endmodule

bind trap_unit trap_unit_chk #(.VEC(VEC)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .take           (take_w),
    .eret_go        (eret_go),
    .csr_we         (csr_we),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .kernel_mode    (kernel_mode),
    .epc            (epc_out),
    .cause          (cause_out),
    .badva          (badvaddr_out)
);

// File: tb/tb_trap_unit.sv
module tb_trap_unit;
    localparam logic [31:0] VEC    = 32'h8000_0180;
    localparam logic [31:0] W_ERET = 32'h4200_0018;
    localparam logic [31:0] W_SYS  = 32'h0000_000C;
    localparam logic [31:0] W_BRK  = 32'h0000_000D;
    localparam logic [31:0] W_ALU  = 32'h2000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ex_valid = 1'b0;
    logic [31:0] ex_pc = '0;
    logic [31:0] ex_instr = W_ALU;
    logic        resv_in = 1'b0, ibus_err = 1'b0, ovf_in = 1'b0, trap_in = 1'b0, fpe_in = 1'b0;
    logic        mem_ld = 1'b0, mem_st = 1'b0, dbus_err = 1'b0;
    logic [1:0]  mem_size = 2'd2;
    logic [31:0] mem_vaddr = '0;
    logic [5:0]  irq_in = '0;
    logic        nmi_in = 1'b1;
    logic        csr_we = 1'b0;
    logic [6:0]  csr_wdata = '0;

    logic        redirect_valid, kernel_mode;
    logic [31:0] redirect_pc, epc_out, badvaddr_out;
    logic [5:0]  irq_mask;
    logic [4:0]  cause_out;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // reference model state
    logic        m_k, m_prev, m_pend, e_rv;
    logic [5:0]  m_mask;
    logic [31:0] m_epc, m_bad, e_rpc;
    logic [4:0]  m_cause;
    string       e_tag;

    trap_unit dut (
        .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .ex_pc(ex_pc), .ex_instr(ex_instr),
        .resv_in(resv_in), .ibus_err(ibus_err), .ovf_in(ovf_in), .trap_in(trap_in),
        .fpe_in(fpe_in), .mem_ld(mem_ld), .mem_st(mem_st), .mem_size(mem_size),
        .mem_vaddr(mem_vaddr), .dbus_err(dbus_err), .irq_in(irq_in), .nmi_in(nmi_in),
        .csr_we(csr_we), .csr_wdata(csr_wdata), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .kernel_mode(kernel_mode), .irq_mask(irq_mask),
        .epc_out(epc_out), .cause_out(cause_out), .badvaddr_out(badvaddr_out)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input string fld, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: act=%h exp=%h (t=%0t)", tag, fld, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk({"R1 ", e_tag}, "redirect_valid", {31'd0, redirect_valid}, {31'd0, e_rv});
        chk({"R1 ", e_tag}, "redirect_pc", redirect_pc, e_rpc);
        chk({"R1 ", e_tag}, "kernel_mode", {31'd0, kernel_mode}, {31'd0, m_k});
        chk({"R12 ", e_tag}, "irq_mask", {26'd0, irq_mask}, {26'd0, m_mask});
        chk({"R2 ", e_tag}, "epc", epc_out, m_epc);
        chk({"R3 ", e_tag}, "cause", {27'd0, cause_out}, {27'd0, m_cause});
        chk({"R4 ", e_tag}, "badvaddr", badvaddr_out, m_bad);
    endtask

    task automatic model_reset();
        m_k = 1'b1; m_prev = 1'b1; m_pend = 1'b0; m_mask = '0;
        m_epc = '0; m_bad = '0; m_cause = '0; e_rv = 1'b0; e_rpc = '0;
        e_tag = "R11";
    endtask

    // computes the state expected after the coming clock edge from the driven inputs
    task automatic model_step();
        logic fa, fb, ri, sy, bp, da, db, er, ig, ng, mis, take, nxt, bwe, erg;
        logic [4:0]  code;
        logic [31:0] bval;
        int nsrc;
        string tag;
        fa = 0; fb = 0; ri = 0; sy = 0; bp = 0; da = 0; db = 0; er = 0;
        take = 0; nxt = 0; bwe = 0; erg = 0; code = 5'd0; bval = '0; tag = "R13";
        mis = (mem_size == 2'd0) ? 1'b0 : (mem_size == 2'd1) ? mem_vaddr[0] : (mem_vaddr[1:0] != 0);
        if (ex_valid) begin
            fa = (ex_pc[1:0] != 0) || (!m_k && ex_pc[31]);
            fb = ibus_err;
            ri = resv_in || (ex_instr == W_ERET && !m_k);
            er = (ex_instr == W_ERET) && m_k;
            sy = ex_instr[31:26] == 0 && ex_instr[5:0] == 6'h0C;
            bp = ex_instr[31:26] == 0 && ex_instr[5:0] == 6'h0D;
            if (mem_ld || mem_st) begin
                da = mis || (!m_k && mem_vaddr[31]);
                db = dbus_err;
            end
        end
        ng = ex_valid && m_pend;
        ig = ex_valid && !m_k && ((irq_in & m_mask) != 0);
        nsrc = int'(ng) + int'(fa) + int'(fb) + int'(ri) + int'(sy) + int'(bp) + int'(da) + int'(db) + int'(ig) + int'(er)
             + int'(ex_valid && ovf_in) + int'(ex_valid && trap_in) + int'(ex_valid && fpe_in);
        if (ng) begin take = 1; tag = "R8"; end
        else if (fa) begin take = 1; code = 4; bwe = 1; bval = ex_pc; tag = "R5"; end
        else if (fb) begin take = 1; code = 6; end
        else if (ri) begin take = 1; code = 10; tag = "R6"; end
        else if (sy) begin take = 1; code = 8; nxt = 1; tag = "R6"; end
        else if (bp) begin take = 1; code = 9; nxt = 1; tag = "R6"; end
        else if (ex_valid && ovf_in) begin take = 1; code = 12; nxt = 1; end
        else if (ex_valid && trap_in) begin take = 1; code = 13; nxt = 1; end
        else if (ex_valid && fpe_in) begin take = 1; code = 15; nxt = 1; end
        else if (da) begin take = 1; code = mem_st ? 5'd5 : 5'd4; bwe = 1; bval = mem_vaddr; tag = "R5"; end
        else if (db) begin take = 1; code = 7; end
        else if (ig) begin take = 1; tag = "R7"; end
        else if (er) begin erg = 1; tag = "R10"; end
        if (nsrc > 1) tag = "R9";
        e_rv = take || erg;
        if (take) begin
            e_rpc = VEC; m_k = 1; m_cause = code;
            m_epc = nxt ? ex_pc + 32'd4 : ex_pc;
            if (bwe) m_bad = bval;
            if (ng) m_pend = 0;
        end else if (erg) begin
            e_rpc = m_epc; m_k = 0;
        end else if (csr_we) begin
            tag = "R12";
            if (m_k) begin m_k = csr_wdata[0]; m_mask = csr_wdata[6:1]; end
        end
        if (nmi_in && !m_prev) m_pend = 1;
        m_prev = nmi_in;
        e_tag = tag;
    endtask

    task automatic run_cycle();
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        ex_valid = 0; ex_pc = 32'h0000_1000; ex_instr = W_ALU; resv_in = 0; ibus_err = 0;
        ovf_in = 0; trap_in = 0; fpe_in = 0; mem_ld = 0; mem_st = 0; mem_size = 2'd2;
        mem_vaddr = '0; dbus_err = 0; irq_in = '0; csr_we = 0; csr_wdata = '0;
    endtask

    task automatic go_user(input logic [5:0] mask);
        idle(); csr_we = 1; csr_wdata = {mask, 1'b0}; run_cycle();
    endtask

    function automatic logic pick(input int n);
        return ($urandom % n) == 0;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: act=running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] seed;
        seed = $urandom(32'd20240611);
        idle();
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset values with nmi_in held high through reset
        compare_all();
        // R8: level held from reset must not count as an edge
        ex_valid = 1; run_cycle(); run_cycle();
        // R8: real edge after a low phase, taken in kernel mode
        idle(); nmi_in = 0; run_cycle(); nmi_in = 1; run_cycle();
        ex_valid = 1; ex_pc = 32'h0000_2000; run_cycle();
        // R12: kernel write then ignored user write
        go_user(6'h15);
        idle(); csr_we = 1; csr_wdata = 7'h7F; run_cycle();
        // R7: masked line ignored, enabled line taken
        idle(); ex_valid = 1; ex_pc = 32'h0000_3000; irq_in = 6'h02; run_cycle();
        irq_in = 6'h04; run_cycle();
        // R6: exception return in user mode becomes reserved instruction
        go_user(6'h3F);
        idle(); ex_valid = 1; ex_pc = 32'h0000_4000; ex_instr = W_ERET; run_cycle();
        // R10: exception return from kernel
        idle(); ex_valid = 1; ex_instr = W_ERET; run_cycle();
        // R9: syscall with pending interrupt
        idle(); ex_valid = 1; ex_pc = 32'h0000_4010; ex_instr = W_SYS; irq_in = 6'h3F; run_cycle();
        // R5: user store into kernel half, after returning
        idle(); ex_valid = 1; ex_instr = W_ERET; run_cycle();
        idle(); ex_valid = 1; ex_pc = 32'h0000_4020; mem_st = 1; mem_vaddr = 32'h8000_0010; run_cycle();
        // R9: misaligned fetch beats breakpoint and data fault
        idle(); ex_valid = 1; ex_pc = 32'h0000_5002; ex_instr = W_BRK; mem_ld = 1; mem_size = 2'd1;
        mem_vaddr = 32'h0000_0001; ovf_in = 1; run_cycle();
        // R5: halfword load misaligned in kernel
        idle(); ex_valid = 1; ex_pc = 32'h0000_5004; mem_ld = 1; mem_size = 2'd1; mem_vaddr = 32'h0000_0103; run_cycle();
        // R13: idle cycles
        idle(); run_cycle(); run_cycle();

        for (int i = 0; i < 4000; i++) begin
            idle();
            ex_valid = !pick(5);
            ex_pc = {pick(6), 27'($urandom), pick(12) ? 2'($urandom) : 2'b00, 2'b00};
            ex_pc = {ex_pc[31:4], 2'b00, ex_pc[3:2]};
            case ($urandom % 8)
                0: ex_instr = W_SYS;
                1: ex_instr = W_BRK;
                2: ex_instr = W_ERET;
                default: ex_instr = W_ALU | {6'd0, 26'($urandom)};
            endcase
            resv_in = pick(20); ibus_err = pick(25); ovf_in = pick(15);
            trap_in = pick(15); fpe_in = pick(18);
            mem_ld = pick(4); mem_st = !mem_ld && pick(4);
            mem_size = 2'($urandom); mem_vaddr = $urandom; dbus_err = pick(15);
            irq_in = pick(3) ? 6'($urandom) : 6'd0;
            nmi_in = pick(30) ? !nmi_in : nmi_in;
            csr_we = pick(6); csr_wdata = 7'($urandom);
            run_cycle();
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule